// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front-End

This block is the bus-facing protocol engine of a small 256-byte serial memory. It watches a two-wire bus (clock SCL and data SDA), oversampling both lines with the system clock. It recognises start and stop conditions and collects a device select byte. When that byte names this device, the engine acknowledges it and then runs either a write transfer or a read transfer. Data moves to and from an external byte array through simple single-cycle strobes.

The array itself sits outside the block. The engine owns the current-address counter. Writes advance only the low bits of that counter, so a burst stays inside one 8-byte page and wraps back to the start of that page. Reads advance the whole counter and wrap from the top of memory to address zero. SDA is open-drain: the block only ever asserts an output enable that pulls the line low.

Top module: `twiMemSlave`

## Requirements
- R1: While reset is held and directly after it, `sdaOe`, `memWrEn` and `memRdEn` are all 0.
- R2: A device select byte is acknowledged (SDA pulled low in the ninth clock) when bits 7..4 equal 1010 and bits 3..1 equal `strapPins[2:0]`. Bits are sent MSB first, and bit 0 chooses the direction: 1 for read, 0 for write.
- R3: A select byte that fails either the prefix or the strap comparison is not acknowledged. The block then ignores the bus until the next start condition: it gives no acknowledge and no memory strobe.
- R4: In a write, the byte after the select byte becomes the word address, and every later byte is written there. The block acknowledges each of these bytes, and each data byte produces one `memWrEn` pulse with that address and that byte.
- R5: After each written byte, bits 2..0 of the current address increment modulo 8 and bits 7..3 stay the same. Successive bytes of a burst therefore wrap within their 8-byte page.
- R6: In a read, bytes are driven MSB first from the current address. Each byte that is loaded increments the full 8-bit address, and 0xFF is followed by 0x00.
- R7: When the master does not acknowledge a read byte (SDA high in the ninth clock), the block stops driving SDA and stays silent until the next start condition.
- R8: A read that is not preceded by a word address starts at the address that follows the last byte accessed.
- R9: A start condition in the middle of a byte abandons that byte, and reception begins again with a new select byte.
- R10: A stop condition returns the block to idle. Bytes clocked in afterwards without a new start are neither acknowledged nor written.
- R11: The block never pulls SDA low while the master is sending data bits. It changes `sdaOe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strapPins | input | 3 | Board-strapped device select bits |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |
| memAddr | output | 8 | Current array address |
| memWrData | output | 8 | Byte to be written to the array |
| memWrEn | output | 1 | One-cycle write strobe |
| memRdEn | output | 1 | One-cycle read strobe; `memRdData` is taken in this cycle |
| memRdData | input | 8 | Array byte at `memAddr` (combinational read) |

## Verification
A corrupted FSM state shows up at the very next acknowledge slot. The master sees SDA high where it expected low, or SDA low while it is driving a data bit, within nine SCL periods. A wrong address counter produces no visible symptom until the next write strobe or read byte. It then appears as data at the wrong location or a read byte from the wrong cell. For that reason the tests read back across page and memory wrap points rather than only at fresh word addresses.

// File: rtl/twiPkg.sv
package twiPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK
  } twiState_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_WADDR,
    K_WDATA
  } byteKind_e;

  typedef struct packed {
    logic shiftIn;
    logic loadAddr;
    logic writeByte;
    logic readByte;
    logic shiftOut;
  } dpCtrl_t;
endpackage

// File: rtl/twiDatapath.sv
module twiDatapath
  import twiPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3,
  parameter int STRAP_W = 3,
  parameter int PREFIX_W = 4,
  parameter logic [PREFIX_W-1:0] DEV_PREFIX = 4'b1010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapPins,
  input  dpCtrl_t            ctl,
  output logic               sclLvl,
  output logic               sclRise,
  output logic               sclFall,
  output logic               startEv,
  output logic               stopEv,
  output logic               sdaNow,
  output logic               devMatch,
  output logic               devRead,
  output logic               txBit,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWrData,
  output logic               memWrEn,
  output logic               memRdEn,
  input  logic [DATA_W-1:0]  memRdData
);
  localparam int HI_W = DATA_W - PAGE_W;

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic [DATA_W-1:0] rxShift, txShift, addrCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclLvl  = sclSync[1];
  assign sdaNow  = sdaSync[1];
  assign sclRise = sclLvl & ~sclPrev;
  assign sclFall = ~sclLvl & sclPrev;
  assign startEv = sclLvl & sclPrev & sdaPrev & ~sdaNow;
  assign stopEv  = sclLvl & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      addrCnt <= '0;
    end else begin
      if (ctl.shiftIn) rxShift <= {rxShift[DATA_W-2:0], sdaNow};
      if (ctl.readByte) txShift <= memRdData;
      else if (ctl.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b1};
      if (ctl.loadAddr) addrCnt <= rxShift;
      else if (ctl.writeByte)
        addrCnt <= {addrCnt[DATA_W-1:PAGE_W], addrCnt[PAGE_W-1:0] + 1'b1};
      else if (ctl.readByte) addrCnt <= addrCnt + 1'b1;
    end
  end

  assign devMatch = (rxShift[DATA_W-1 -: PREFIX_W] == DEV_PREFIX) &&
                    (rxShift[STRAP_W:1] == strapPins);
  assign devRead   = rxShift[0];
  assign txBit     = txShift[DATA_W-1];
  assign memAddr   = addrCnt;
  assign memWrData = rxShift;
  assign memWrEn   = ctl.writeByte;
  assign memRdEn   = ctl.readByte;

  // R5
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeByte |=> (addrCnt[DATA_W-1:PAGE_W] == $past(addrCnt[DATA_W-1:PAGE_W])) &&
                      (addrCnt[PAGE_W-1:0] == PAGE_W'($past(addrCnt[PAGE_W-1:0]) + 1'b1)));

  // R6
  read_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.readByte |=> addrCnt == DATA_W'($past(addrCnt) + 1'b1));

  // R4
  hold_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadAddr && !ctl.readByte) |=> addrCnt[DATA_W-1:PAGE_W] == $past(addrCnt[DATA_W-1:PAGE_W]));

  logic unusedHi;
  assign unusedHi = ^HI_W;
endmodule

// File: rtl/twiCtrl.sv
module twiCtrl
  import twiPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclLvl,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    startEv,
  input  logic    stopEv,
  input  logic    sdaNow,
  input  logic    devMatch,
  input  logic    devRead,
  input  logic    txBit,
  output dpCtrl_t ctl,
  output logic    sdaOe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  twiState_e state;
  byteKind_e kind;
  logic [CNT_W-1:0] bitCnt;
  logic readDir, mAckLow;
  logic byteDone;

  assign byteDone = (state == ST_RECV) && sclFall && (bitCnt == FULL);

  always_comb begin
    ctl = '0;
    ctl.shiftIn   = (state == ST_RECV) && sclRise && (bitCnt < FULL);
    ctl.loadAddr  = byteDone && (kind == K_WADDR);
    ctl.writeByte = byteDone && (kind == K_WDATA);
    ctl.readByte  = ((state == ST_ACK) && sclFall && (kind == K_DEV) && readDir) ||
                    ((state == ST_MACK) && sclFall && mAckLow);
    ctl.shiftOut  = (state == ST_SEND) && sclFall && (bitCnt != LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kind    <= K_DEV;
      bitCnt  <= '0;
      readDir <= 1'b0;
      mAckLow <= 1'b0;
    end else if (startEv) begin
      state  <= ST_RECV;
      kind   <= K_DEV;
      bitCnt <= '0;
    end else if (stopEv) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_RECV: begin
          if (sclRise && bitCnt < FULL) bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            if (kind != K_DEV) state <= ST_ACK;
            else if (devMatch) begin
              state   <= ST_ACK;
              readDir <= devRead;
            end else state <= ST_IDLE;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (kind == K_DEV && readDir) state <= ST_SEND;
            else begin
              state <= ST_RECV;
              kind  <= (kind == K_DEV) ? K_WADDR : K_WDATA;
            end
          end
        end
        ST_SEND: begin
          if (sclFall) begin
            if (bitCnt == LAST) state <= ST_MACK;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) mAckLow <= ~sdaNow;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= mAckLow ? ST_SEND : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaOe = (state == ST_ACK) || ((state == ST_SEND) && !txBit);

  // R11
  oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLvl);

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopEv && !startEv) |=> state == ST_IDLE);

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (state == ST_RECV && kind == K_DEV && bitCnt == '0));

  // R3
  nomatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && kind == K_DEV && !devMatch && !startEv && !stopEv) |=> state == ST_IDLE);

  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.writeByte && ctl.readByte));
endmodule

// File: rtl/twiMemSlave.sv
module twiMemSlave
  import twiPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 3,
  parameter int STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapPins,
  output logic               sdaOe,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWrData,
  output logic               memWrEn,
  output logic               memRdEn,
  input  logic [DATA_W-1:0]  memRdData
);
  dpCtrl_t ctl;
  logic sclLvl, sclRise, sclFall, startEv, stopEv, sdaNow;
  logic devMatch, devRead, txBit;

  twiDatapath #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .STRAP_W(STRAP_W)) dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapPins(strapPins),
    .ctl(ctl), .sclLvl(sclLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaNow(sdaNow), .devMatch(devMatch),
    .devRead(devRead), .txBit(txBit), .memAddr(memAddr), .memWrData(memWrData),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .memRdData(memRdData)
  );

  twiCtrl #(.DATA_W(DATA_W)) ctrl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaNow(sdaNow), .devMatch(devMatch),
    .devRead(devRead), .txBit(txBit), .ctl(ctl), .sdaOe(sdaOe)
  );
endmodule

// File: tb/twiMemSlave_test.sv
`timescale 1ns/1ps
module twiMemSlave_test;
  localparam int HALF = 8;
  localparam logic [7:0] DEVW = 8'hAA;
  localparam logic [7:0] DEVR = 8'hAB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe, memWrEn, memRdEn;
  logic [7:0] memAddr, memWrData, memRdData;
  logic sdaLine;
  logic [7:0] mem [256];
  int wrCount = 0;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;
  assign memRdData = mem[memAddr];

  twiMemSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .strapPins(3'b101),
    .sdaOe(sdaOe), .memAddr(memAddr), .memWrData(memWrData), .memWrEn(memWrEn),
    .memRdEn(memRdEn), .memRdData(memRdData)
  );

  always @(posedge clk) begin
    if (memWrEn) begin
      mem[memAddr] <= memWrData;
      wrCount <= wrCount + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busBit(input logic b, output logic seen);
    sdaM = b;
    waitClk(HALF);
    sclM = 1'b1;
    waitClk(HALF / 2);
    seen = sdaLine;
    waitClk(HALF / 2);
    sclM = 1'b0;
  endtask

  task automatic busStart();
    sclM = 1'b0; waitClk(HALF);
    sdaM = 1'b1; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b0; waitClk(HALF);
    sclM = 1'b0; waitClk(2);
  endtask

  task automatic busStop();
    sclM = 1'b0; waitClk(HALF);
    sdaM = 1'b0; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b1; waitClk(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackLow);
    logic seen;
    logic clash = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      busBit(b[i], seen);
      if (seen !== b[i]) clash = 1'b1;
    end
    check("R11 slave silent during master bits", clash, 1'b0);
    busBit(1'b1, seen);
    ackLow = ~seen;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] d);
    logic seen;
    for (int i = 7; i >= 0; i--) begin
      busBit(1'b1, seen);
      d[i] = seen;
    end
    busBit(~giveAck, seen);
    sdaM = 1'b1;
  endtask

  task automatic testReset();
    waitClk(3);
    check("R1 oe in reset", sdaOe, 1'b0);
    check("R1 strobes in reset", {memWrEn, memRdEn}, 2'b00);
    rstN = 1'b1;
    waitClk(3);
    check("R1 oe after reset", sdaOe, 1'b0);
    check("R1 no writes", wrCount, 0);
  endtask

  task automatic testByteWrite();
    logic a;
    int w0 = wrCount;
    busStart();
    sendByte(DEVW, a); check("R2 select ack", a, 1'b1);
    sendByte(8'h10, a); check("R4 word addr ack", a, 1'b1);
    sendByte(8'h5C, a); check("R4 data ack", a, 1'b1);
    busStop();
    check("R4 mem[10]", mem[8'h10], 8'h5C);
    check("R4 one write", wrCount - w0, 1);
  endtask

  task automatic testMismatch();
    logic a;
    int w0 = wrCount;
    busStart();
    sendByte(8'hBA, a); check("R3 prefix mismatch nack", a, 1'b0);
    sendByte(8'h20, a); check("R3 ignored byte nack", a, 1'b0);
    sendByte(8'h77, a); check("R3 ignored byte nack 2", a, 1'b0);
    busStop();
    busStart();
    sendByte(8'hA4, a); check("R3 strap mismatch nack", a, 1'b0);
    busStop();
    check("R3 no write", wrCount - w0, 0);
    check("R3 mem[20] kept", mem[8'h20], 8'h7A);
  endtask

  task automatic testPageWrite();
    logic a;
    busStart();
    sendByte(DEVW, a);
    sendByte(8'h1E, a);
    for (int i = 1; i <= 4; i++) begin
      sendByte(8'(i), a);
      check("R5 burst ack", a, 1'b1);
    end
    busStop();
    check("R5 mem[1E]", mem[8'h1E], 8'h01);
    check("R5 mem[1F]", mem[8'h1F], 8'h02);
    check("R5 wrap mem[18]", mem[8'h18], 8'h03);
    check("R5 wrap mem[19]", mem[8'h19], 8'h04);
    check("R5 mem[20] untouched", mem[8'h20], 8'h7A);
  endtask

  task automatic testCurrentRead();
    logic a;
    logic [7:0] d;
    busStart();
    sendByte(DEVR, a); check("R2 read select ack", a, 1'b1);
    readByte(1'b1, d); check("R8 current address byte", d, 8'h40);
    readByte(1'b0, d); check("R6 next byte", d, 8'h41);
    busStop();
    check("R10 oe after stop", sdaOe, 1'b0);
  endtask

  task automatic testWrapRead();
    logic a;
    logic [7:0] d;
    busStart();
    sendByte(DEVW, a);
    sendByte(8'hFE, a);
    busStart();
    sendByte(DEVR, a); check("R6 repeated start ack", a, 1'b1);
    readByte(1'b1, d); check("R6 byte FE", d, 8'hA4);
    readByte(1'b1, d); check("R6 byte FF", d, 8'hA5);
    readByte(1'b0, d); check("R6 wrap to 00", d, 8'h5A);
    sendByte(8'hFF, a); check("R7 silent after nack", a, 1'b0);
    check("R7 oe released", sdaOe, 1'b0);
    busStop();
  endtask

  task automatic testAbort();
    logic a, seen;
    int w0 = wrCount;
    busStart();
    sendByte(DEVW, a);
    busBit(1'b0, seen); busBit(1'b1, seen); busBit(1'b0, seen); busBit(1'b0, seen);
    busStart();
    sendByte(DEVW, a); check("R9 restart select ack", a, 1'b1);
    sendByte(8'h40, a);
    sendByte(8'h99, a);
    busStop();
    check("R9 mem[40]", mem[8'h40], 8'h99);
    check("R9 one write", wrCount - w0, 1);
  endtask

  task automatic testStopIdle();
    logic a;
    int w0 = wrCount;
    busStart();
    sendByte(DEVW, a);
    sendByte(8'h30, a);
    busStop();
    sclM = 1'b0; waitClk(HALF);
    sendByte(8'h66, a); check("R10 no ack after stop", a, 1'b0);
    busStop();
    check("R10 no write", wrCount - w0, 0);
    check("R10 mem[30] kept", mem[8'h30], 8'h6A);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    testReset();
    testByteWrite();
    testMismatch();
    testPageWrite();
    testCurrentRead();
    testWrapRead();
    testAbort();
    testStopIdle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule